// File: doc/BRIEF.md
# SDRAM Sequential Read Sequencer with Row Crossing

This block drives the command and address pins of a single-bank SDRAM for one sequential read burst at a time. A master presents a start address and a beat count. The address is split into a row part in the upper bits and a column part in the lower bits. The sequencer opens the row and waits out the activate-to-read delay. It then issues one read command per clock on consecutive columns. It raises a data-valid strobe in step with the CAS latency.

A burst may run past the last column of the open row. In that case the sequencer handles the crossing on its own, without a new request from the master. It closes the row with a precharge and waits the precharge recovery time. It then opens the next row, wrapping from the last row back to row zero, and goes on reading from column zero. Data stays in address order across the crossing. Every burst ends by closing the row it used. The master sees a busy flag until the final data beat has appeared.

Top module: `sdr_burst_rd_seq`

## Requirements
- R1: After synchronous active-high reset, the pins show no-operation, the address is zero, and both busy and rd_valid are low.
- R2: The command on the active-low pins (cs_n, ras_n, cas_n, we_n) is one of four values. Activate is 0,0,1,1; read is 0,1,0,1; precharge is 0,0,1,0; no-operation is 0,1,1,1. Activate drives the row on sd_addr, read drives the column zero-extended, and every other command drives zero.
- R3: A request with a nonzero length, taken while the block is idle, puts an activate of the start row on the pins in the next cycle.
- R4: The first read to a newly opened row comes exactly T_RCD (3) cycles after its activate, with no-operation in between.
- R5: While beats remain and the row has not ended, reads follow on consecutive cycles, and the column rises by one each time.
- R6: After a read of the last column (all ones) with beats still left, a precharge follows in the next cycle. The activate of row+1 (the last row wraps to 0) follows exactly T_RP (3) cycles after the precharge. Reading then resumes at column 0.
- R7: rd_valid is high exactly CAS_LAT (2) cycles after each read command, and never at any other time. It pulses once per requested beat.
- R8: The cycle after the final read of a burst carries a precharge, so the row is closed.
- R9: busy is high from the cycle after acceptance through the cycle of the final data beat. It falls one cycle later, and at that point a new request is accepted. Idle cycles show no-operation.
- R10: A request made while busy is ignored, and so is a request with a length of zero. Neither changes the pins or the busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request strobe, sampled while idle |
| req_addr | input | ROW_W+COL_W | Start address, {row, column} |
| req_len | input | LEN_W | Beat count; zero is ignored |
| busy | output | 1 | High while a burst is in progress |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | max(ROW_W,COL_W) | Row or column address |
| rd_valid | output | 1 | Read data beat present on the memory data bus |

## Verification
The assertions assume that the only commands the device sees are the ones this block issues. They assume the bank starts closed after reset, so an activate is legal without an earlier precharge. They also assume that any column step between reads stays inside one row. The stimulus respects these assumptions: it raises requests only from the bench's own tasks, and it keeps start addresses and lengths inside the parameter ranges. Some requests are placed in the middle of a burst and some have a length of zero. These exercise the cases that must be ignored, but the bench still waits for busy to fall before it issues each real burst.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_PRE
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_TRCD,
        ST_READ,
        ST_PRE_X,
        ST_TRP,
        ST_PRE_END,
        ST_DRAIN
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_pins_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic sdr_pins_t encode_cmd(input sdr_cmd_e c);
        sdr_pins_t p;
        case (c)
            CMD_ACT: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
            CMD_RD:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
            CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

    function automatic sdr_cmd_e state_cmd(input seq_state_e s);
        case (s)
            ST_ACT:     return CMD_ACT;
            ST_READ:    return CMD_RD;
            ST_PRE_X:   return CMD_PRE;
            ST_PRE_END: return CMD_PRE;
            default:    return CMD_NOP;
        endcase
    endfunction

endpackage

// File: rtl/sdr_rd_cursor.sv
module sdr_rd_cursor #(
    parameter int COL_W = 4,
    parameter int ROW_W = 4,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] ld_row,
    input  logic [COL_W-1:0] ld_col,
    input  logic [LEN_W-1:0] ld_len,
    input  logic             step,
    output logic [ROW_W-1:0] row_q,
    output logic [COL_W-1:0] col_q,
    output logic             last,
    output logic             wrap
);
    localparam logic [COL_W-1:0] COL_END = {COL_W{1'b1}};

    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
            rem_q <= '0;
        end else if (load) begin
            row_q <= ld_row;
            col_q <= ld_col;
            rem_q <= ld_len;
        end else if (step) begin
            col_q <= col_q + 1'b1;
            rem_q <= rem_q - 1'b1;
            if (col_q == COL_END) begin
                row_q <= row_q + 1'b1;
            end
        end
    end

    assign last = (rem_q == LEN_W'(1));
    assign wrap = (col_q == COL_END);

endmodule

// File: rtl/sdr_rd_ctrl.sv
module sdr_rd_ctrl
    import sdr_rd_pkg::*;
#(
    parameter int T_RCD   = 3,
    parameter int T_RP    = 3,
    parameter int CAS_LAT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_go,
    input  logic       last,
    input  logic       wrap,
    output seq_state_e state_q,
    output logic       load,
    output logic       step
);
    localparam int END_GAP = imax(T_RP, CAS_LAT + 1) - 2;
    localparam int CNT_MAX = imax(imax(T_RCD, T_RP), END_GAP + 1);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_e       state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        step    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_go) begin
                    state_d = ST_ACT;
                    load    = 1'b1;
                end
            end
            ST_ACT: begin
                state_d = ST_TRCD;
                cnt_d   = CNT_W'(T_RCD - 2);
            end
            ST_TRCD: begin
                if (cnt_q == '0) state_d = ST_READ;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_READ: begin
                step = 1'b1;
                if (last)      state_d = ST_PRE_END;
                else if (wrap) state_d = ST_PRE_X;
            end
            ST_PRE_X: begin
                state_d = ST_TRP;
                cnt_d   = CNT_W'(T_RP - 2);
            end
            ST_TRP: begin
                if (cnt_q == '0) state_d = ST_ACT;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_PRE_END: begin
                if (END_GAP == 0) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_DRAIN;
                    cnt_d   = CNT_W'(END_GAP - 1);
                end
            end
            ST_DRAIN: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/sdr_rd_pins.sv
module sdr_rd_pins
    import sdr_rd_pkg::*;
#(
    parameter int ROW_W   = 4,
    parameter int COL_W   = 4,
    parameter int ADDR_W  = 4,
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    output sdr_pins_t         pins,
    output logic [ADDR_W-1:0] addr,
    output logic              rd_valid
);
    sdr_cmd_e           cmd;
    logic [CAS_LAT-1:0] rd_pipe;

    always_comb begin
        cmd  = state_cmd(state);
        pins = encode_cmd(cmd);
        case (cmd)
            CMD_ACT: addr = ADDR_W'(row);
            CMD_RD:  addr = ADDR_W'(col);
            default: addr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pipe <= '0;
        end else begin
            rd_pipe[0] <= (cmd == CMD_RD);
            for (int i = 1; i < CAS_LAT; i++) begin
                rd_pipe[i] <= rd_pipe[i-1];
            end
        end
    end

    assign rd_valid = rd_pipe[CAS_LAT-1];

endmodule

// File: rtl/sdr_burst_rd_seq.sv
module sdr_burst_rd_seq
    import sdr_rd_pkg::*;
#(
    parameter int COL_W   = 4,
    parameter int ROW_W   = 4,
    parameter int LEN_W   = 6,
    parameter int T_RCD   = 3,
    parameter int T_RP    = 3,
    parameter int CAS_LAT = 2,
    localparam int AW     = ROW_W + COL_W,
    localparam int ADDR_W = imax(ROW_W, COL_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              rd_valid
);
    seq_state_e       state;
    logic             load, step, last, wrap, req_go;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    sdr_pins_t        pins;

    assign req_go = req_valid && (req_len != '0);

    sdr_rd_ctrl #(
        .T_RCD  (T_RCD),
        .T_RP   (T_RP),
        .CAS_LAT(CAS_LAT)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .req_go (req_go),
        .last   (last),
        .wrap   (wrap),
        .state_q(state),
        .load   (load),
        .step   (step)
    );

    sdr_rd_cursor #(
        .COL_W(COL_W),
        .ROW_W(ROW_W),
        .LEN_W(LEN_W)
    ) u_cursor (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .ld_row(req_addr[AW-1:COL_W]),
        .ld_col(req_addr[COL_W-1:0]),
        .ld_len(req_len),
        .step  (step),
        .row_q (row_q),
        .col_q (col_q),
        .last  (last),
        .wrap  (wrap)
    );

    sdr_rd_pins #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W),
        .CAS_LAT(CAS_LAT)
    ) u_pins (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .row     (row_q),
        .col     (col_q),
        .pins    (pins),
        .addr    (sd_addr),
        .rd_valid(rd_valid)
    );

    assign busy     = (state != ST_IDLE);
    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;

endmodule

// File: rtl/sdr_burst_rd_chk.sv
module sdr_burst_rd_chk #(
    parameter int ADDR_W  = 4,
    parameter int T_RCD   = 3,
    parameter int T_RP    = 3,
    parameter int CAS_LAT = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              rd_valid
);
    logic [3:0] code;
    logic       is_act, is_rd, is_pre, is_nop;
    logic [7:0] since_act, since_pre;
    logic [CAS_LAT-1:0] rd_hist;

    assign code   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_act = (code == 4'b0011);
    assign is_rd  = (code == 4'b0101);
    assign is_pre = (code == 4'b0010);
    assign is_nop = (code == 4'b0111);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= 8'hFF;
            since_pre <= 8'hFF;
            rd_hist   <= '0;
        end else begin
            since_act  <= is_act ? 8'd1 : ((since_act == 8'hFF) ? since_act : since_act + 8'd1);
            since_pre  <= is_pre ? 8'd1 : ((since_pre == 8'hFF) ? since_pre : since_pre + 8'd1);
            rd_hist[0] <= is_rd;
            for (int i = 1; i < CAS_LAT; i++) begin
                rd_hist[i] <= rd_hist[i-1];
            end
        end
    end

    assert_cmd_legal_R2: assert property (@(posedge clk) disable iff (rst)
        is_act || is_rd || is_pre || is_nop);

    assert_rcd_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (is_rd && !$past(is_rd)) |-> (since_act >= 8'(T_RCD)));

    assert_col_step_R5: assert property (@(posedge clk) disable iff (rst)
        (is_rd && $past(is_rd)) |-> (sd_addr == ADDR_W'($past(sd_addr) + 1'b1)));

    assert_rp_gap_R6: assert property (@(posedge clk) disable iff (rst)
        is_act |-> (since_pre >= 8'(T_RP)));

    assert_valid_has_read_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_hist[CAS_LAT-1]);

    assert_read_gives_valid_R7: assert property (@(posedge clk) disable iff (rst)
        rd_hist[CAS_LAT-1] |-> rd_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (is_nop && !rd_hist[CAS_LAT-1]));

endmodule

bind sdr_burst_rd_seq sdr_burst_rd_chk #(
    .ADDR_W (ADDR_W),
    .T_RCD  (T_RCD),
    .T_RP   (T_RP),
    .CAS_LAT(CAS_LAT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .sd_cs_n (sd_cs_n),
    .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n),
    .sd_we_n (sd_we_n),
    .sd_addr (sd_addr),
    .rd_valid(rd_valid)
);

// File: tb/sdr_burst_rd_seq_bench.sv
`timescale 1ns/1ps
module sdr_burst_rd_seq_bench;
    localparam int COL_W = 4;
    localparam int ROW_W = 4;
    localparam int LEN_W = 6;
    localparam int TRCD  = 3;
    localparam int TRP   = 3;
    localparam int CL    = 2;
    localparam int NCOL  = 1 << COL_W;
    localparam int NROW  = 1 << ROW_W;
    localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_PRE = 3;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   req_valid = 1'b0;
    logic [ROW_W+COL_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]       req_len = '0;
    logic                   busy, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, rd_valid;
    logic [3:0]             sd_addr;

    int n_checks = 0;
    int n_errors = 0;
    int exp_cmd [0:511];
    int exp_adr [0:511];
    int n_exp;
    int last_rd;
    int idx;

    always #10 clk = ~clk;

    sdr_burst_rd_seq #(
        .COL_W(COL_W), .ROW_W(ROW_W), .LEN_W(LEN_W),
        .T_RCD(TRCD), .T_RP(TRP), .CAS_LAT(CL)
    ) u_sdr_burst_rd_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .busy(busy), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .rd_valid(rd_valid)
    );

    function automatic int pin_code();
        case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
            4'b0111: return C_NOP;
            4'b0011: return C_ACT;
            4'b0101: return C_RD;
            4'b0010: return C_PRE;
            default: return 9;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input int c, input int a);
        exp_cmd[idx] = c;
        exp_adr[idx] = a;
        idx++;
    endtask

    task automatic build(input int row, input int col, input int len);
        int r = row;
        int c = col;
        idx = 0;
        push(C_ACT, r);
        for (int k = 0; k < TRCD - 1; k++) push(C_NOP, 0);
        for (int b = 0; b < len; b++) begin
            push(C_RD, c);
            last_rd = idx - 1;
            c++;
            if (c == NCOL && b < len - 1) begin
                push(C_PRE, 0);
                for (int k = 0; k < TRP - 1; k++) push(C_NOP, 0);
                r = (r + 1) % NROW;
                push(C_ACT, r);
                for (int k = 0; k < TRCD - 1; k++) push(C_NOP, 0);
                c = 0;
            end
        end
        push(C_PRE, 0);
        n_exp = last_rd + ((TRP > CL + 1) ? TRP : CL + 1);
        while (idx < n_exp) push(C_NOP, 0);
    endtask

    // Starts at a falling edge with the design idle; ends at a falling edge.
    task automatic run_burst(input int row, input int col, input int len, input bit inj);
        int beats = 0;
        string tag;
        build(row, col, len);
        req_valid = 1'b1;
        req_addr  = (ROW_W+COL_W)'((row << COL_W) | col);
        req_len   = LEN_W'(len);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < n_exp; i++) begin
            case (exp_cmd[i])
                C_ACT:   tag = (i == 0) ? "R3" : "R6";
                C_RD:    tag = "R5";
                C_PRE:   tag = (i == last_rd + 1) ? "R8" : "R6";
                default: tag = "R4";
            endcase
            check(pin_code() == exp_cmd[i], tag, "command", pin_code(), exp_cmd[i]);
            check(int'(sd_addr) == exp_adr[i], "R2", "address", int'(sd_addr), exp_adr[i]);
            check(rd_valid == (i >= CL && exp_cmd[i-CL] == C_RD), "R7", "rd_valid",
                  int'(rd_valid), int'(i >= CL && exp_cmd[i-CL] == C_RD));
            check(busy == 1'b1, "R9", "busy in burst", int'(busy), 1);
            if (rd_valid) beats++;
            if (inj && i == 4) begin
                req_valid = 1'b1;
                req_addr  = (ROW_W+COL_W)'($urandom);
                req_len   = LEN_W'(1 + $urandom % 60);
            end else begin
                req_valid = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
        end
        check(beats == len, "R7", "beat count", beats, len);
        check(busy == 1'b0, inj ? "R10" : "R9", "busy after burst", int'(busy), 0);
        check(pin_code() == C_NOP && !rd_valid, "R9", "idle pins", pin_code(), C_NOP);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(pin_code() == C_NOP, "R1", "reset command", pin_code(), C_NOP);
        check(sd_addr == '0, "R1", "reset address", int'(sd_addr), 0);
        check(!busy && !rd_valid, "R1", "reset busy/valid", int'(busy), 0);

        // length zero is ignored
        req_valid = 1'b1;
        req_addr  = 8'h35;
        req_len   = '0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check(!busy && pin_code() == C_NOP, "R10", "zero-length request",
                  int'(busy), 0);
            @(posedge clk);
            @(negedge clk);
        end

        run_burst(0, 0, 1, 1'b0);
        run_burst(2, 15, 2, 1'b0);     // crosses at once
        run_burst(15, 14, 20, 1'b1);   // last row wraps to row 0
        run_burst(5, 0, 63, 1'b0);     // longest burst, several crossings
        run_burst(7, 3, 13, 1'b1);     // ends exactly on the last column

        for (int t = 0; t < 40; t++) begin
            run_burst(int'($urandom % NROW), int'($urandom % NCOL),
                      int'(1 + $urandom % 63), 1'($urandom % 2));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule